// File: doc/BRIEF.md
# Two-Wire Switch Management Master

This block is a hardware master for a two-wire management bus that reaches the register file of an Ethernet switch. The bus has a clock line and a bidirectional data line. They are wired the way MDC/MDIO are wired, but the framing is not MDIO. Each transaction is opened by a start pattern: two clock pulses, with a data fall during the second high phase. The master then sends bytes most-significant bit first, and the target must confirm each byte with an active-low acknowledge bit. The transaction is closed by a stop pattern, after which both lines are released to high impedance.

A host issues one 16-bit register access at a time through a valid/ready request port. The request carries a direction, a 16-bit address, 16-bit write data and a flag that skips the acknowledge of the last write byte. Skipping that acknowledge is needed for a write that resets the target, because such a target never answers. The result comes back as a one-cycle response pulse carrying the read data and an error flag. The error flag is set when an acknowledge was refused on six consecutive samples. Every line change is spaced by a programmable number of system clock cycles, and the read and write command byte values are parameters.

Top module: `sw_mgmt_master`

## Requirements
- R1: After reset, and whenever no transaction is in progress, both line enables (`mg_clk_oe`, `mg_dat_oe`) are low, `req_ready` is high and `rsp_valid` is low.
- R2: A transaction opens with the clock driven low and data driven high. One full clock pulse follows. On the second clock rise, data falls while the clock stays high, then the clock falls and data returns high. Exactly two clock rises come before the data fall.
- R3: Every transmitted byte is sent most-significant bit first. Each bit is placed on data while the clock is low, and data does not change while the clock is high inside a bit.
- R4: After each byte that needs an acknowledge, the master releases data, pulses the clock and samples data just before the clock falls. A sampled 0 is an acknowledge and a sampled 1 is resampled. The sixth consecutive 1 ends the transaction with `rsp_err` = 1.
- R5: A read sends the read command byte, then address bits [7:0], then address bits [15:8], and each byte is acknowledged. It then clocks in data bits [7:0] and drives a 0, then clocks in data bits [15:8] and drives a 1. The assembled value is returned on `rsp_rdata`.
- R6: A write sends the write command byte, address [7:0], address [15:8], data [7:0] and data [15:8] in that order, and each byte is acknowledged. It returns `rsp_err` = 0 when all five acknowledges arrive.
- R7: With `req_noack` = 1, a write sends its last byte without an acknowledge slot and reports no error. With `req_noack` = 0, the same refused last byte leads to the timeout of R4.
- R8: An acknowledge timeout stops any further byte from being sent. The stop pattern is still produced before the response pulse, and `rsp_rdata` is 0 on an aborted read.
- R9: The stop pattern raises the clock with data low, then raises data while the clock is high. It adds two more full clock pulses ending with the clock high, then releases both lines; at the release the clock output is high.
- R10: `req_ready` is low from the cycle after a request is accepted until the cycle after `rsp_valid`, which lasts one cycle.
- R11: Two successive changes of the clock line are never closer than `HALF_CYC` system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle and able to accept |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_addr | input | 16 | Target register address |
| req_wdata | input | 16 | Write data |
| req_noack | input | 1 | Skip the acknowledge of the last write byte |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 16 | Read data (0 for writes and aborted reads) |
| rsp_err | output | 1 | Acknowledge timeout occurred |
| mg_clk_o | output | 1 | Bus clock level |
| mg_clk_oe | output | 1 | Bus clock output enable |
| mg_dat_o | output | 1 | Bus data level driven by the master |
| mg_dat_oe | output | 1 | Bus data output enable |
| mg_dat_i | input | 1 | Resolved bus data level |

## Verification
The assertions assume that `mg_dat_i` is already synchronous to `clk` and is driven by the target only while the master has released data. They also assume the target changes data only while the clock line is low, so a sample taken at the end of the high phase is stable. The behavioural target in the bench keeps to this. It updates its drive only on clock falls, drives only while `mg_dat_oe` is low, and otherwise leaves the line pulled high. The bench issues requests only while `req_ready` is high.

// File: rtl/sw_mgmt_pkg.sv
// Shared types of the two-wire management master.
// Assumes nothing beyond the IEEE 1800-2017 type system.
package sw_mgmt_pkg;

    localparam int BYTE_W = 8;

    // Line-level operations the bit engine can carry out.
    typedef enum logic [1:0] {
        OP_START,
        OP_TX,
        OP_RX,
        OP_STOP
    } phy_op_e;

    // Transaction sequencer states.
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_TXB,
        S_ACK,
        S_RXB,
        S_MACK,
        S_STOP,
        S_RESP
    } seq_st_e;

endpackage

// File: rtl/sw_mgmt_tick.sv
// Half-period timer: while run is high, pulses tick once every HALF_CYC cycles.
// restart reloads the count so the first tick arrives HALF_CYC cycles later.
// Assumes HALF_CYC >= 1.
module sw_mgmt_tick #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Down-counter reloaded on restart and on every expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= RELOAD;
        end else if (run) begin
            cnt_q <= (cnt_q == '0) ? RELOAD : cnt_q - 1'b1;
        end
    end

    assign tick = run && !restart && (cnt_q == '0);

endmodule

// File: rtl/sw_mgmt_phy.sv
// Bit engine: runs one line operation (start pattern, transmit bit, receive
// bit, stop pattern) as a list of steps, each one applied after one
// half-period. Pulses op_done when the last step is applied; rx_bit holds
// the data sampled by a receive step.
// Assumes op_go is only raised while busy is low and mg_dat_i is synchronous.
module sw_mgmt_phy
    import sw_mgmt_pkg::*;
#(
    parameter int HALF_CYC = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    op_go,
    input  phy_op_e op_kind,
    input  logic    op_bit,
    output logic    busy,
    output logic    op_done,
    output logic    rx_bit,
    output logic    mg_clk_o,
    output logic    mg_clk_oe,
    output logic    mg_dat_o,
    output logic    mg_dat_oe,
    input  logic    mg_dat_i
);
    logic       busy_q, done_q, rx_q, bit_q;
    logic       ck_q, ckoe_q, dt_q, dtoe_q;
    phy_op_e    kind_q;
    logic [2:0] step_q, last_step;
    logic       tick;

    sw_mgmt_tick #(.HALF_CYC(HALF_CYC)) tick_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (op_go),
        .run     (busy_q),
        .tick    (tick)
    );

    // Index of the final step for the running operation.
    always_comb begin
        case (kind_q)
            OP_START: last_step = 3'd6;
            OP_STOP:  last_step = 3'd7;
            default:  last_step = 3'd2;
        endcase
    end

    // Step sequencer and line registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            rx_q   <= 1'b0;
            bit_q  <= 1'b0;
            kind_q <= OP_START;
            step_q <= '0;
            ck_q   <= 1'b1;
            ckoe_q <= 1'b0;
            dt_q   <= 1'b1;
            dtoe_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (op_go) begin
                busy_q <= 1'b1;
                kind_q <= op_kind;
                bit_q  <= op_bit;
                step_q <= '0;
            end else if (busy_q && tick) begin
                case (kind_q)
                    OP_START: case (step_q)
                        3'd0: begin ckoe_q <= 1'b1; dtoe_q <= 1'b1; ck_q <= 1'b0; dt_q <= 1'b1; end
                        3'd1: ck_q <= 1'b1;
                        3'd2: ck_q <= 1'b0;
                        3'd3: ck_q <= 1'b1;
                        3'd4: dt_q <= 1'b0;
                        3'd5: ck_q <= 1'b0;
                        default: dt_q <= 1'b1;
                    endcase
                    OP_TX: case (step_q)
                        3'd0: begin dtoe_q <= 1'b1; dt_q <= bit_q; end
                        3'd1: ck_q <= 1'b1;
                        default: ck_q <= 1'b0;
                    endcase
                    OP_RX: case (step_q)
                        3'd0: dtoe_q <= 1'b0;
                        3'd1: ck_q <= 1'b1;
                        default: begin rx_q <= mg_dat_i; ck_q <= 1'b0; end
                    endcase
                    default: case (step_q)
                        3'd0: begin dtoe_q <= 1'b1; dt_q <= 1'b0; ck_q <= 1'b1; end
                        3'd1: dt_q <= 1'b1;
                        3'd2: ck_q <= 1'b1;
                        3'd3: ck_q <= 1'b0;
                        3'd4: ck_q <= 1'b1;
                        3'd5: ck_q <= 1'b0;
                        3'd6: ck_q <= 1'b1;
                        default: begin ckoe_q <= 1'b0; dtoe_q <= 1'b0; end
                    endcase
                endcase
                if (step_q == last_step) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end
        end
    end

    assign busy      = busy_q;
    assign op_done   = done_q;
    assign rx_bit    = rx_q;
    assign mg_clk_o  = ck_q;
    assign mg_clk_oe = ckoe_q;
    assign mg_dat_o  = dt_q;
    assign mg_dat_oe = dtoe_q;

    // R3: inside a transmitted bit, data holds while the clock is high.
    a_r3_data_steady_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && kind_q == OP_TX && ck_q && $past(ck_q)) |-> $stable(dt_q));

    // R10: the sequencer never starts an operation over a running one.
    a_r10_go_only_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        op_go |-> !busy_q);

    // R9: the clock is left high at the moment both lines are released.
    a_r9_release_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ckoe_q) |-> (ck_q && !dtoe_q));

endmodule

// File: rtl/sw_mgmt_master.sv
// Two-wire switch management master. Accepts one 16-bit register access,
// frames it (start, command, address, data, acknowledges, stop) through the
// bit engine and returns a one-cycle response with read data and error flag.
// Assumes the target only changes data while the clock line is low.
module sw_mgmt_master
    import sw_mgmt_pkg::*;
#(
    parameter logic [7:0] CMD_RD      = 8'hB1,
    parameter logic [7:0] CMD_WR      = 8'hB0,
    parameter int         HALF_CYC    = 4,
    parameter int         ACK_RETRIES = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_rd,
    input  logic [15:0] req_addr,
    input  logic [15:0] req_wdata,
    input  logic        req_noack,
    output logic        rsp_valid,
    output logic [15:0] rsp_rdata,
    output logic        rsp_err,
    output logic        mg_clk_o,
    output logic        mg_clk_oe,
    output logic        mg_dat_o,
    output logic        mg_dat_oe,
    input  logic        mg_dat_i
);
    localparam int          RW        = $clog2(ACK_RETRIES + 1);
    localparam logic [RW-1:0] RETRY_MAX = RW'(ACK_RETRIES);
    localparam logic [2:0]  RD_LAST_TX = 3'd2;
    localparam logic [2:0]  WR_LAST_TX = 3'd4;

    seq_st_e           st_q;
    logic              wait_q, rd_q, noack_q, hi_q, err_q;
    logic [15:0]       addr_q, wdata_q, rdata_q;
    logic [2:0]        byte_q, bit_q;
    logic [RW-1:0]     retry_q;
    logic [BYTE_W-1:0] sh_q, tx_byte, rx_byte;
    logic              op_go, op_bit, busy, op_done, rx_bit;
    phy_op_e           op_kind;

    sw_mgmt_phy #(.HALF_CYC(HALF_CYC)) phy_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_go     (op_go),
        .op_kind   (op_kind),
        .op_bit    (op_bit),
        .busy      (busy),
        .op_done   (op_done),
        .rx_bit    (rx_bit),
        .mg_clk_o  (mg_clk_o),
        .mg_clk_oe (mg_clk_oe),
        .mg_dat_o  (mg_dat_o),
        .mg_dat_oe (mg_dat_oe),
        .mg_dat_i  (mg_dat_i)
    );

    // Byte selected for transmission by the current byte index.
    always_comb begin
        case (byte_q)
            3'd0:    tx_byte = rd_q ? CMD_RD : CMD_WR;
            3'd1:    tx_byte = addr_q[7:0];
            3'd2:    tx_byte = addr_q[15:8];
            3'd3:    tx_byte = wdata_q[7:0];
            default: tx_byte = wdata_q[15:8];
        endcase
    end

    // Operation request toward the bit engine for the current state.
    always_comb begin
        op_go = !wait_q && (st_q != S_IDLE) && (st_q != S_RESP);
        case (st_q)
            S_START:       op_kind = OP_START;
            S_ACK, S_RXB:  op_kind = OP_RX;
            S_STOP:        op_kind = OP_STOP;
            default:       op_kind = OP_TX;
        endcase
        op_bit = (st_q == S_MACK) ? hi_q : tx_byte[bit_q];
    end

    assign rx_byte = {sh_q[BYTE_W-2:0], rx_bit};

    // Transaction sequencer: accept, frame, acknowledge handling, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= S_IDLE;
            wait_q  <= 1'b0;
            rd_q    <= 1'b0;
            noack_q <= 1'b0;
            hi_q    <= 1'b0;
            err_q   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            byte_q  <= '0;
            bit_q   <= '0;
            retry_q <= '0;
            sh_q    <= '0;
        end else begin
            if (op_go)   wait_q <= 1'b1;
            if (op_done) wait_q <= 1'b0;
            case (st_q)
                S_IDLE: if (req_valid) begin
                    rd_q    <= req_rd;
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    noack_q <= req_noack;
                    err_q   <= 1'b0;
                    rdata_q <= '0;
                    st_q    <= S_START;
                end
                S_START: if (op_done) begin
                    byte_q <= '0;
                    bit_q  <= 3'd7;
                    st_q   <= S_TXB;
                end
                S_TXB: if (op_done) begin
                    if (bit_q != 3'd0) begin
                        bit_q <= bit_q - 1'b1;
                    end else if (!rd_q && byte_q == WR_LAST_TX && noack_q) begin
                        st_q <= S_STOP;
                    end else begin
                        retry_q <= '0;
                        st_q    <= S_ACK;
                    end
                end
                S_ACK: if (op_done) begin
                    if (!rx_bit) begin
                        bit_q <= 3'd7;
                        if (rd_q && byte_q == RD_LAST_TX) begin
                            hi_q <= 1'b0;
                            st_q <= S_RXB;
                        end else if (!rd_q && byte_q == WR_LAST_TX) begin
                            st_q <= S_STOP;
                        end else begin
                            byte_q <= byte_q + 1'b1;
                            st_q   <= S_TXB;
                        end
                    end else if (retry_q == RETRY_MAX) begin
                        err_q <= 1'b1;
                        st_q  <= S_STOP;
                    end else begin
                        retry_q <= retry_q + 1'b1;
                    end
                end
                S_RXB: if (op_done) begin
                    sh_q <= rx_byte;
                    if (bit_q == 3'd0) begin
                        if (hi_q) rdata_q[15:8] <= rx_byte;
                        else      rdata_q[7:0]  <= rx_byte;
                        st_q <= S_MACK;
                    end else begin
                        bit_q <= bit_q - 1'b1;
                    end
                end
                S_MACK: if (op_done) begin
                    if (hi_q) begin
                        st_q <= S_STOP;
                    end else begin
                        hi_q  <= 1'b1;
                        bit_q <= 3'd7;
                        st_q  <= S_RXB;
                    end
                end
                S_STOP: if (op_done) st_q <= S_RESP;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign req_ready = (st_q == S_IDLE);
    assign rsp_valid = (st_q == S_RESP);
    assign rsp_rdata = rdata_q;
    assign rsp_err   = err_q;

    // R10: no second request is taken while one is in flight.
    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10: the response pulse is followed by readiness.
    a_r10_ready_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (req_ready && !rsp_valid));

    // R1: lines are released whenever the master is idle.
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mg_clk_oe && !mg_dat_oe));

    // R8: the response never comes while the bus is still driven.
    a_r8_stop_before_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!mg_clk_oe && mg_clk_o));

endmodule

// File: tb/sw_mgmt_master_tb_top.sv
// Scoreboard bench with a behavioural bus target.
module sw_mgmt_master_tb_top;
    localparam int         HALF = 3;
    localparam logic [7:0] CRD  = 8'h5B;
    localparam logic [7:0] CWR  = 8'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        req_valid = 1'b0, req_rd = 1'b0, req_noack = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_err;
    logic [15:0] rsp_rdata;
    logic        mc_o, mc_oe, md_o, md_oe, md_i;

    sw_mgmt_master #(.CMD_RD(CRD), .CMD_WR(CWR), .HALF_CYC(HALF), .ACK_RETRIES(5)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_rd(req_rd), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_noack(req_noack), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .mg_clk_o(mc_o), .mg_clk_oe(mc_oe),
        .mg_dat_o(md_o), .mg_dat_oe(md_oe), .mg_dat_i(md_i)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Scoreboard queues.
    logic [7:0]  exp_bytes[$];
    logic        exp_mack[$];
    logic [16:0] exp_rsp[$];

    // Target state.
    logic        in_frame = 0, rose = 0, cap_bit = 0, cap_oe = 0;
    logic        need_ack = 0, rd_phase = 0, mack_pend = 0, is_read = 0;
    logic        prev_mc = 1, prev_md = 1, prev_mcoe = 0, after_stop = 0;
    logic [7:0]  shreg = '0;
    int          bitn = 0, byte_n = 0, rd_cnt = 0, rd_idx = 0;
    int          hold_byte = -1, hold_left = 0, ack_samples = 0;
    int          starts = 0, stops = 0, pre_rises = 0, post_rises = 0;
    int          since_mc = 1000;
    logic [15:0] t_word = '0;
    logic        mc_l, md_l, t_en, t_val;

    // Resolved bus lines with pull-ups.
    always_comb begin
        t_en  = in_frame && !md_oe && (need_ack || rd_phase);
        t_val = need_ack ? ((byte_n - 1 == hold_byte) && hold_left > 0)
                         : t_word[rd_idx*8 + 7 - rd_cnt];
        mc_l  = mc_oe ? mc_o : 1'b1;
        md_l  = md_oe ? md_o : (t_en ? t_val : 1'b1);
    end
    assign md_i = md_l;

    // Behavioural target and line monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mc_l != prev_mc) begin
                chk(since_mc >= HALF, "R11", "clock line spacing", since_mc, HALF);
                since_mc = 1;
            end else if (since_mc < 1000) since_mc++;
            if (mc_oe && !prev_mcoe) begin pre_rises = 0; after_stop = 0; end
            if (!mc_oe && prev_mcoe) begin
                chk(post_rises == 2, "R9", "clock pulses after stop", post_rises, 2);
                chk(mc_o && !md_oe, "R9", "release with clock high", {mc_o, md_oe}, 2'b10);
            end
            if (mc_l && prev_mc && prev_md && !md_l && !in_frame) begin
                chk(pre_rises == 2, "R2", "clock rises before start fall", pre_rises, 2);
                in_frame = 1; rose = 0; starts++; bitn = 0; byte_n = 0;
                need_ack = 0; rd_phase = 0; mack_pend = 0; is_read = 0;
            end else if (mc_l && prev_mc && !prev_md && md_l && in_frame) begin
                in_frame = 0; rose = 0; stops++; post_rises = 0; after_stop = 1;
                rd_phase = 0; need_ack = 0;
            end else if (!prev_mc && mc_l) begin
                if (in_frame) begin rose = 1; cap_bit = md_l; cap_oe = md_oe; end
                else if (after_stop) post_rises++;
                else pre_rises++;
            end else if (prev_mc && !mc_l && rose) begin
                rose = 0;
                if (cap_oe) begin
                    if (mack_pend) begin
                        mack_pend = 0;
                        if (exp_mack.size() == 0)
                            chk(0, "R5", "unexpected master ack bit", cap_bit, 0);
                        else begin
                            logic e;
                            e = exp_mack.pop_front();
                            chk(cap_bit == e, "R5", "master ack bit", cap_bit, e);
                        end
                        if (rd_idx < 2) rd_phase = 1;
                    end else begin
                        shreg = {shreg[6:0], cap_bit};
                        bitn++;
                        if (bitn == 8) begin
                            bitn = 0;
                            if (byte_n == 0) is_read = (shreg == CRD);
                            byte_n++;
                            need_ack = 1;
                            if (exp_bytes.size() == 0)
                                chk(0, "R8", "byte sent after abort or extra byte", shreg, 0);
                            else begin
                                logic [7:0] eb;
                                eb = exp_bytes.pop_front();
                                chk(shreg == eb, "R3", "byte on the bus", shreg, eb);
                            end
                        end
                    end
                end else if (need_ack) begin
                    ack_samples++;
                    if (!cap_bit) begin
                        need_ack = 0;
                        if (is_read && byte_n == 3) begin
                            rd_phase = 1; rd_cnt = 0; rd_idx = 0;
                        end
                    end else hold_left--;
                end else if (rd_phase) begin
                    rd_cnt++;
                    if (rd_cnt == 8) begin
                        rd_cnt = 0; rd_idx++; rd_phase = 0; mack_pend = 1;
                    end
                end
            end
            prev_mc = mc_l; prev_md = md_l; prev_mcoe = mc_oe;
        end
    end

    // Response monitor: pops the scoreboard on each response pulse.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_rsp.size() == 0) chk(0, "R10", "unexpected response", 1, 0);
            else begin
                logic [16:0] e;
                e = exp_rsp.pop_front();
                chk(rsp_rdata == e[15:0], "R5", "response data", rsp_rdata, e[15:0]);
                chk(rsp_err == e[16], "R4", "response error flag", rsp_err, e[16]);
            end
        end
    end

    // Driver: pushes expectations, issues the request, checks side effects.
    task automatic run_txn(input string req, input logic rd, input logic [15:0] a,
                           input logic [15:0] wd, input logic na, input logic [15:0] tw,
                           input int hb, input int hn, input int nbytes,
                           input logic err, input int samples);
        logic [7:0] all[5];
        int s0;
        bit busy_ok;
        all[0] = rd ? CRD : CWR; all[1] = a[7:0]; all[2] = a[15:8];
        all[3] = wd[7:0]; all[4] = wd[15:8];
        for (int i = 0; i < nbytes; i++) exp_bytes.push_back(all[i]);
        if (rd && !err) begin exp_mack.push_back(1'b0); exp_mack.push_back(1'b1); end
        exp_rsp.push_back({err, (rd && !err) ? tw : 16'h0000});
        t_word = tw; hold_byte = hb; hold_left = hn; ack_samples = 0; s0 = stops;
        @(negedge clk);
        req_valid = 1; req_rd = rd; req_addr = a; req_wdata = wd; req_noack = na;
        @(negedge clk);
        req_valid = 0;
        busy_ok = 1;
        while (!rsp_valid) begin
            if (req_ready) busy_ok = 0;
            @(negedge clk);
        end
        chk(busy_ok, "R10", "ready low while busy", busy_ok, 1);
        @(negedge clk);
        chk(req_ready && !rsp_valid, "R10", "ready after response", req_ready, 1);
        chk(exp_bytes.size() == 0, {req, "/R8"}, "bytes missing", exp_bytes.size(), 0);
        chk(exp_mack.size() == 0, "R5", "master acks missing", exp_mack.size(), 0);
        chk(ack_samples == samples, "R4", "acknowledge samples", ack_samples, samples);
        chk(stops == s0 + 1, "R9", "one stop per transaction", stops - s0, 1);
        exp_bytes.delete(); exp_mack.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mc_oe && !md_oe, "R1", "reset state",
            {req_ready, rsp_valid, mc_oe, md_oe}, 4'b1000);
        // R6: plain acknowledged write
        run_txn("R6", 0, 16'h1234, 16'hBEEF, 0, 16'h0, -1, 0, 5, 0, 5);
        // R5: read with data returned low byte first
        run_txn("R5", 1, 16'h8001, 16'h0, 0, 16'hC35A, -1, 0, 3, 0, 3);
        // R4: five refusals on the command byte are still within the bound
        run_txn("R4", 1, 16'h00F0, 16'h0, 0, 16'h0F0F, 0, 5, 3, 0, 8);
        // R4 R8: sixth refusal on address low aborts the write
        run_txn("R8", 0, 16'h4321, 16'h5555, 0, 16'h0, 1, 6, 2, 1, 7);
        // R7: last byte sent without acknowledge slot
        run_txn("R7", 0, 16'h00FE, 16'hA5C3, 1, 16'h0, 4, 100, 5, 0, 4);
        // R7: same refusal with acknowledge required times out
        run_txn("R7", 0, 16'h00FE, 16'hA5C3, 0, 16'h0, 4, 100, 5, 1, 10);
        // R8: read aborted on address high returns zero data
        run_txn("R8", 1, 16'h7E81, 16'h0, 0, 16'hFFFF, 2, 6, 3, 1, 8);
        // R2 R3: another read with distinct patterns
        run_txn("R2", 1, 16'hFFFF, 16'h0, 0, 16'h8001, -1, 0, 3, 0, 3);
        chk(starts == 8, "R2", "start patterns seen", starts, 8);
        chk(exp_rsp.size() == 0, "R10", "responses missing", exp_rsp.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule